// File: doc/BRIEF.md
# Memory Access Wait-State Calculator

This block prices a single bus access in wait cycles. A requester presents the top byte of the target address, whether the access is sequential or not, its width, a flag that tells whether the display is currently drawing, and the cartridge timing selects for wait state 0. The block decodes the region and applies the cost rule for that region. The rules are a fixed cost for external work RAM, a fixed cost plus a drawing penalty for the three video memories, and table lookups for the cartridge window. It returns the count one clock later together with a valid strobe.

Regions that cost nothing (boot ROM, internal work RAM, I/O and every unmapped code) return zero. The cartridge windows for wait states 1 and 2 are not priced here. They return zero and raise an unsupported flag, so the caller can tell a real zero apart from a missing rule. The cartridge first-access and second-access tables are parameters, so other timing sets can be built without touching the logic.

Top module: `wait_cost_calc`

## Requirements
- R1: During and right after a synchronous reset, `rsp_valid`, `rsp_cycles` and `rsp_unsupported` are all zero.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock edge, and only then. While `req_valid` is low, `rsp_cycles` and `rsp_unsupported` keep their last values.
- R3: Region 0x02 costs 6 cycles for a word access and 3 for a byte or halfword access. This holds whatever the draw flag and wait selects are.
- R4: Regions 0x05, 0x06 and 0x07 cost 2 cycles for a word access and 1 otherwise. One extra cycle is added when `draw_active` is 1.
- R5: Regions 0x08 and 0x09, non-sequential (`req_seq`=0), byte or halfword: the cost is the first-access table entry chosen by `ws_first_sel`. The table holds 4, 3, 2, 8 for select values 0, 1, 2, 3.
- R6: Regions 0x08 and 0x09, non-sequential, word: the cost is the first-access entry plus the second-access entry. The second-access entry is chosen by `ws_second_sel`, which maps 0 to 2 and 1 to 1.
- R7: Regions 0x08 and 0x09, sequential (`req_seq`=1): the cost is one second-access entry for byte or halfword, and twice that entry for word.
- R8: Regions 0x00, 0x01, 0x03, 0x04 and every code from 0x0E upward cost 0 cycles, with `rsp_unsupported` at 0.
- R9: Regions 0x0A to 0x0D return 0 cycles with `rsp_unsupported` at 1. Every other region returns `rsp_unsupported` at 0.
- R10: Width encoding: 00 is byte, 01 is halfword, 10 is word, and the spare code 11 is costed exactly as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_region | input | 8 | Top byte of the access address |
| req_seq | input | 1 | 1 = sequential access, 0 = non-sequential |
| req_width | input | 2 | Access width code (see R10) |
| draw_active | input | 1 | Display is in its drawing period |
| ws_first_sel | input | 2 | Cartridge first-access table index |
| ws_second_sel | input | 1 | Cartridge second-access table index |
| rsp_valid | output | 1 | Result strobe, one clock after the request |
| rsp_cycles | output | 5 | Cycle cost of the access |
| rsp_unsupported | output | 1 | Region has no cost rule in this block |

## Verification
The hardest case to reach is the cartridge word access. Only there do two table lookups combine, so a wrong index, a swapped table, or a doubled entry where a sum belongs is hidden unless every first/second select pair meets every type and width. The stimulus is therefore a full cross of all sixteen low region codes plus two high codes, both access types, all four width codes including the spare one, both draw states and every table index. Requests are issued back to back, so each registered result is overwritten on the very next cycle. An idle stretch at the end then shows that the last value holds.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_XRAM  = 3'd1,
    RC_VIDEO = 3'd2,
    RC_CART  = 3'd3,
    RC_UNSUP = 3'd4
  } region_class_e;

  // Width code: bit 1 set means a word (the spare code 11 included).
  function automatic logic width_is_word(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/wsc_region_decode.sv
module wsc_region_decode
  import wsc_pkg::*;
#(
  parameter int unsigned REGION_W  = 8,
  parameter int unsigned XRAM_CODE = 2,
  parameter int unsigned VIDEO_LO  = 5,
  parameter int unsigned VIDEO_HI  = 7,
  parameter int unsigned CART_LO   = 8,
  parameter int unsigned CART_HI   = 9,
  parameter int unsigned UNSUP_LO  = 10,
  parameter int unsigned UNSUP_HI  = 13
) (
  input  logic [REGION_W-1:0] region,
  output region_class_e       cls
);

  localparam int unsigned CODE_MAX = (1 << REGION_W) - 1;

  int unsigned code;

  always_comb begin
    code = int'(region);
    if (code > CODE_MAX)
      cls = RC_NONE;
    else if (code == XRAM_CODE)
      cls = RC_XRAM;
    else if (code >= VIDEO_LO && code <= VIDEO_HI)
      cls = RC_VIDEO;
    else if (code >= CART_LO && code <= CART_HI)
      cls = RC_CART;
    else if (code >= UNSUP_LO && code <= UNSUP_HI)
      cls = RC_UNSUP;
    else
      cls = RC_NONE;
  end

endmodule

// File: rtl/wsc_cart_cost.sv
module wsc_cart_cost #(
  parameter int unsigned CYC_W        = 5,
  parameter int unsigned FIRST_SEL_W  = 2,
  parameter int unsigned SECOND_SEL_W = 1,
  parameter int unsigned FIRST_COST  [2**FIRST_SEL_W]  = '{4, 3, 2, 8},
  parameter int unsigned SECOND_COST [2**SECOND_SEL_W] = '{2, 1}
) (
  input  logic                    seq,
  input  logic                    is_word,
  input  logic [FIRST_SEL_W-1:0]  first_sel,
  input  logic [SECOND_SEL_W-1:0] second_sel,
  output logic [CYC_W-1:0]        cost
);

  localparam int unsigned FIRST_N  = 2**FIRST_SEL_W;
  localparam int unsigned SECOND_N = 2**SECOND_SEL_W;

  logic [CYC_W-1:0] first_tbl  [FIRST_N];
  logic [CYC_W-1:0] second_tbl [SECOND_N];

  for (genvar i = 0; i < FIRST_N; i++) begin : g_first
    assign first_tbl[i] = CYC_W'(FIRST_COST[i]);
  end

  for (genvar j = 0; j < SECOND_N; j++) begin : g_second
    assign second_tbl[j] = CYC_W'(SECOND_COST[j]);
  end

  logic [CYC_W-1:0] first_c;
  logic [CYC_W-1:0] second_c;

  assign first_c  = first_tbl[first_sel];
  assign second_c = second_tbl[second_sel];

  always_comb begin
    if (!seq)
      cost = is_word ? (first_c + second_c) : first_c;
    else
      cost = is_word ? (second_c + second_c) : second_c;
  end

endmodule

// File: rtl/wsc_fixed_cost.sv
module wsc_fixed_cost
  import wsc_pkg::*;
#(
  parameter int unsigned CYC_W        = 5,
  parameter int unsigned XRAM_WORD    = 6,
  parameter int unsigned XRAM_NARROW  = 3,
  parameter int unsigned VID_WORD     = 2,
  parameter int unsigned VID_NARROW   = 1,
  parameter int unsigned DRAW_PENALTY = 1
) (
  input  region_class_e    cls,
  input  logic             is_word,
  input  logic             draw_active,
  output logic [CYC_W-1:0] cost
);

  logic [CYC_W-1:0] vid_base;
  logic [CYC_W-1:0] vid_extra;

  assign vid_base  = is_word ? CYC_W'(VID_WORD) : CYC_W'(VID_NARROW);
  assign vid_extra = draw_active ? CYC_W'(DRAW_PENALTY) : '0;

  always_comb begin
    unique case (cls)
      RC_XRAM:  cost = is_word ? CYC_W'(XRAM_WORD) : CYC_W'(XRAM_NARROW);
      RC_VIDEO: cost = vid_base + vid_extra;
      default:  cost = '0;
    endcase
  end

endmodule

// File: rtl/wait_cost_calc.sv
module wait_cost_calc
  import wsc_pkg::*;
#(
  parameter int unsigned REGION_W     = 8,
  parameter int unsigned CYC_W        = 5,
  parameter int unsigned FIRST_SEL_W  = 2,
  parameter int unsigned SECOND_SEL_W = 1,
  parameter int unsigned FIRST_COST  [2**FIRST_SEL_W]  = '{4, 3, 2, 8},
  parameter int unsigned SECOND_COST [2**SECOND_SEL_W] = '{2, 1}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [REGION_W-1:0]     req_region,
  input  logic                    req_seq,
  input  logic [1:0]              req_width,
  input  logic                    draw_active,
  input  logic [FIRST_SEL_W-1:0]  ws_first_sel,
  input  logic [SECOND_SEL_W-1:0] ws_second_sel,
  output logic                    rsp_valid,
  output logic [CYC_W-1:0]        rsp_cycles,
  output logic                    rsp_unsupported
);

  region_class_e    cls;
  logic             is_word;
  logic [CYC_W-1:0] cart_cost;
  logic [CYC_W-1:0] fixed_cost;
  logic [CYC_W-1:0] next_cycles;
  logic             next_unsup;

  assign is_word = width_is_word(req_width);

  wsc_region_decode #(
    .REGION_W (REGION_W)
  ) u_decode (
    .region (req_region),
    .cls    (cls)
  );

  wsc_cart_cost #(
    .CYC_W        (CYC_W),
    .FIRST_SEL_W  (FIRST_SEL_W),
    .SECOND_SEL_W (SECOND_SEL_W),
    .FIRST_COST   (FIRST_COST),
    .SECOND_COST  (SECOND_COST)
  ) u_cart (
    .seq        (req_seq),
    .is_word    (is_word),
    .first_sel  (ws_first_sel),
    .second_sel (ws_second_sel),
    .cost       (cart_cost)
  );

  wsc_fixed_cost #(
    .CYC_W (CYC_W)
  ) u_fixed (
    .cls         (cls),
    .is_word     (is_word),
    .draw_active (draw_active),
    .cost        (fixed_cost)
  );

  assign next_cycles = (cls == RC_CART) ? cart_cost : fixed_cost;
  assign next_unsup  = (cls == RC_UNSUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_cycles      <= '0;
      rsp_unsupported <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cycles      <= next_cycles;
        rsp_unsupported <= next_unsup;
      end
    end
  end

endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int unsigned REGION_W = 8,
  parameter int unsigned CYC_W    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [REGION_W-1:0] req_region,
  input logic                rsp_valid,
  input logic [CYC_W-1:0]    rsp_cycles,
  input logic                rsp_unsupported
);

  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_cycles) && $stable(rsp_unsupported)));

  // R9
  unsup_zero_cost_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_unsupported) |-> (rsp_cycles == '0));

  // R9
  unsup_region_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_unsupported ==
                   ($past(req_region) >= REGION_W'(8'h0A) &&
                    $past(req_region) <= REGION_W'(8'h0D))));

  // R8
  free_region_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_region <= REGION_W'(1) || req_region == REGION_W'(3) ||
                   req_region == REGION_W'(4) || req_region >= REGION_W'(8'h0E)))
    |=> (rsp_cycles == '0));

  // R4
  video_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_region >= REGION_W'(5) && req_region <= REGION_W'(7))
    |=> (rsp_cycles != '0));

endmodule

bind wait_cost_calc wsc_checker #(
  .REGION_W (REGION_W),
  .CYC_W    (CYC_W)
) u_chk (.*);

// File: tb/wait_cost_calc_tb.sv
`timescale 1ns/1ps
module wait_cost_calc_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_region = '0;
  logic       req_seq = 1'b0;
  logic [1:0] req_width = '0;
  logic       draw_active = 1'b0;
  logic [1:0] ws_first_sel = '0;
  logic       ws_second_sel = 1'b0;
  logic       rsp_valid;
  logic [4:0] rsp_cycles;
  logic       rsp_unsupported;

  always #4 clk = ~clk;

  wait_cost_calc u_dut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_region (req_region),
    .req_seq (req_seq), .req_width (req_width), .draw_active (draw_active),
    .ws_first_sel (ws_first_sel), .ws_second_sel (ws_second_sel),
    .rsp_valid (rsp_valid), .rsp_cycles (rsp_cycles),
    .rsp_unsupported (rsp_unsupported)
  );

  typedef struct {
    int    cycles;
    bit    unsup;
    string tag;
    int    region;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   last_cycles = 0;
  bit   last_unsup = 1'b0;

  function automatic void ref_cost(input int region, input bit seq, input int w,
                                   input bit draw, input int fs, input int ss,
                                   output exp_t e);
    int first_t [4];
    int second_t [2];
    bit word;
    first_t  = '{4, 3, 2, 8};
    second_t = '{2, 1};
    word = (w >= 2);
    e.region = region;
    e.unsup  = 1'b0;
    e.cycles = 0;
    if (region == 2) begin
      e.cycles = word ? 6 : 3;
      e.tag = "R3";
    end else if (region >= 5 && region <= 7) begin
      e.cycles = (word ? 2 : 1) + (draw ? 1 : 0);
      e.tag = "R4";
    end else if (region == 8 || region == 9) begin
      if (!seq && !word) begin e.cycles = first_t[fs]; e.tag = "R5"; end
      else if (!seq)     begin e.cycles = first_t[fs] + second_t[ss]; e.tag = "R6"; end
      else               begin e.cycles = word ? 2 * second_t[ss] : second_t[ss]; e.tag = "R7"; end
    end else if (region >= 8'h0A && region <= 8'h0D) begin
      e.unsup = 1'b1;
      e.tag = "R9";
    end else begin
      e.tag = "R8";
    end
    if (w == 3 && e.tag != "R8" && e.tag != "R9")
      e.tag = "R10";
  endfunction

  task automatic send(input int region, input bit seq, input int w,
                      input bit draw, input int fs, input int ss);
    exp_t e;
    @(negedge clk);
    req_valid     = 1'b1;
    req_region    = 8'(region);
    req_seq       = seq;
    req_width     = 2'(w);
    draw_active   = draw;
    ws_first_sel  = 2'(fs);
    ws_second_sel = ss[0];
    ref_cost(region, seq, w, draw, fs, ss, e);
    exp_q.push_back(e);
    last_cycles = e.cycles;
    last_unsup  = e.unsup;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pop and compare each result as it appears.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: response with no request, actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(rsp_cycles) != e.cycles || rsp_unsupported != e.unsup) begin
          n_bad++;
          $display("FAIL %s: region=%02h actual cycles=%0d unsup=%0d expected cycles=%0d unsup=%0d",
                   e.tag, e.region, rsp_cycles, rsp_unsupported, e.cycles, e.unsup);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs are zero while in reset
    check("R1", int'(rsp_valid), 0);
    check("R1", int'(rsp_cycles), 0);
    check("R1", int'(rsp_unsupported), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(rsp_valid), 0);
    check("R1", int'(rsp_cycles), 0);

    // Full sweep, requests back to back.
    for (int r = 0; r < 18; r++) begin
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 4; w++)
          for (int d = 0; d < 2; d++)
            for (int f = 0; f < 4; f++)
              for (int q = 0; q < 2; q++)
                send((r < 16) ? r : ((r == 16) ? 8'h40 : 8'hFF), s[0], w, d[0], f, q);
    end

    // A few isolated requests with gaps between them.
    send(8, 0, 2, 0, 3, 0);   // R6: 8 + 2 = 10
    idle();
    send(9, 1, 3, 1, 0, 0);   // R10/R7: 2 * 2 = 4
    idle();
    idle();
    send(8'h0C, 0, 0, 0, 0, 0);  // R9
    idle();
    send(6, 0, 2, 1, 2, 1);   // R4: 2 + 1 = 3
    idle();
    repeat (4) @(negedge clk);

    // R2: no response while idle and the last result holds
    check("R2", int'(rsp_valid), 0);
    check("R2", int'(rsp_cycles), last_cycles);
    check("R2", int'(rsp_unsupported), int'(last_unsup));
    check("R2", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule